// File: doc/BRIEF.md
# Multi-Channel Match Timer

This block is a register-mapped timer with three independent 32-bit up-counters. Each counter owns three match comparators, a sticky status bit per comparator, and an interrupt enable bit per comparator. A counter runs either periodically, restarting from zero when its first comparator matches, or freely, wrapping at the top of its range. One level-sensitive interrupt line collects every enabled status bit in the block. A shared `tick` input stands in for the prescaled timebase, so a counter advances only in cycles where `tick` is high.

Software reads a live count in two steps. A write to a counter's capture register latches the count. After a short synchronisation delay the latched value can be read from the same register, and a busy flag reports when that delay has passed.

The register port is a request channel with valid/ready. A request is accepted in a cycle where both `bus_valid` and `bus_ready` are high. The master must hold the address, write flag and write data stable while `bus_valid` is high and `bus_ready` is low. `bus_ready` is low only while reset is held. A read returns its data with a one-cycle `rd_valid` pulse. The response channel has no back-pressure, so the master must take the data in that cycle.

Register map, in word addresses:
- Run register at 0x00, one bit per counter.
- Mode register at 0x01, one bit per counter.
- Capture-busy register at 0x02, read-only, one bit per counter.
- Counter c occupies 0x10 + 8c onwards:
  - +0 is status, one bit per comparator.
  - +1 is interrupt enable, one bit per comparator.
  - +2 is capture.
  - +3, +4 and +5 are match values 0, 1 and 2.

Top module: `match_timer`

## Requirements
- R1: Bit c of the run register (address 0x00) enables counter c. A write that changes bit c from 0 to 1 sets that count to zero at the write.
- R2: An enabled counter adds one on each cycle where `tick` is high. In a cycle where `tick` is low, the count does not change.
- R3: A disabled counter keeps its count and its status bits unchanged, whatever `tick` does.
- R4: Status bit k of a counter (offset +0, bit k) sets on a counted tick where the count equals match value k. With match value N-1, the bit sets on the Nth tick after enable.
- R5: When mode bit c (address 0x01) is 1, the counter is periodic. A counted tick where the count equals match value 0 loads zero, which gives a period of match0+1 ticks. Comparators 1 and 2 still set their status bits and do not reload.
- R6: When mode bit c is 0, the counter is free-running. A match does not reload it, and it wraps from 0xFFFFFFFF to 0.
- R7: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. If a clear and a match land in the same cycle, the bit ends up set.
- R8: `irq` is high exactly while some status bit has its enable bit set (offset +1, bit k). It stays high until the bit is cleared or masked.
- R9: A write to the capture register (offset +2) latches the count as it stood in the write cycle. Capture-busy bit c (address 0x02) is high for the two cycles after the write. After busy clears, a read of the capture register returns the latched value, and ticks after the write do not alter it.
- R10: `bus_ready` is high whenever reset is released. Read data arrives with `rd_valid` exactly one cycle after the read is accepted. Unmapped addresses read as zero, and writes to them change no register.
- R11: After reset:
  - The run, mode, status, enable and busy registers read zero.
  - Every match value reads 0xFFFFFFFF.
  - `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count enable from the timebase |
| bus_valid | input | 1 | Register request valid |
| bus_ready | output | 1 | Register request accepted when high with valid |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Word address |
| bus_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid, one-cycle pulse |
| rd_data | output | 32 | Read data |
| irq | output | 1 | Level interrupt, OR of enabled status bits |

## Verification
Some properties are checked by assertions on every cycle:
- A count is cleared by a start, frozen when the counter is off or no tick is present, reloaded on a periodic match, and wrapped at the top of the range in free-running mode.
- Status bits are never lost without a clear.
- The capture-busy flag lasts two cycles.
- Read responses appear exactly one cycle after a read is accepted and never at any other time.
- The interrupt stays low when nothing is enabled.

Other behaviour shows only in the bench scenarios, through values that must be compared with computed ones:
- The exact count returned by a capture.
- The tick on which a match value of N-1 fires.
- The periodic sequence with two comparators active.
- The set-beats-clear outcome.
- Reset contents.
- Unmapped-address behaviour.

// File: rtl/mtmr_pkg.sv
package mtmr_pkg;
  // Register layout (word addresses)
  localparam int unsigned ADR_RUN       = 0;
  localparam int unsigned ADR_MODE      = 1;
  localparam int unsigned ADR_BUSY      = 2;
  localparam int unsigned ADR_CH_BASE   = 16;
  localparam int unsigned ADR_CH_STRIDE = 8;
  localparam int unsigned OFS_STAT      = 0;
  localparam int unsigned OFS_IE        = 1;
  localparam int unsigned OFS_CAP       = 2;
  localparam int unsigned OFS_MATCH     = 3;

  typedef enum logic [2:0] {
    REG_NONE,
    REG_RUN,
    REG_MODE,
    REG_BUSY,
    REG_STAT,
    REG_IE,
    REG_CAP,
    REG_MATCH
  } reg_kind_e;

  typedef struct packed {
    reg_kind_e  kind;
    logic [7:0] ch;
    logic [7:0] idx;
  } reg_sel_t;
endpackage

// File: rtl/mtmr_bus.sv
module mtmr_bus
  import mtmr_pkg::*;
#(
  parameter int unsigned AW   = 8,
  parameter int unsigned DW   = 32,
  parameter int unsigned NCNT = 3,
  parameter int unsigned NCMP = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_valid,
  output logic          bus_ready,
  input  logic          bus_write,
  input  logic [AW-1:0] bus_addr,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  input  logic [DW-1:0] rd_word,
  output reg_sel_t      sel,
  output logic          wr_acc
);
  localparam int unsigned STRIDE_SH = $clog2(ADR_CH_STRIDE);
  localparam int unsigned CH_END    = ADR_CH_BASE + NCNT * ADR_CH_STRIDE;

  logic          ready_q;
  logic          acc;
  logic [AW-1:0] ofs;
  int unsigned   lo_i;

  assign bus_ready = ready_q;
  assign acc       = bus_valid && ready_q;
  assign wr_acc    = acc && bus_write;

  always_ff @(posedge clk) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= 1'b1;
  end

  // Address decode
  always_comb begin
    sel  = '{kind: REG_NONE, ch: '0, idx: '0};
    ofs  = bus_addr - AW'(ADR_CH_BASE);
    lo_i = 32'(ofs[STRIDE_SH-1:0]);
    if (bus_addr == AW'(ADR_RUN)) begin
      sel.kind = REG_RUN;
    end else if (bus_addr == AW'(ADR_MODE)) begin
      sel.kind = REG_MODE;
    end else if (bus_addr == AW'(ADR_BUSY)) begin
      sel.kind = REG_BUSY;
    end else if (bus_addr >= AW'(ADR_CH_BASE) && bus_addr < AW'(CH_END)) begin
      sel.ch = 8'(ofs >> STRIDE_SH);
      if (lo_i == OFS_STAT)      sel.kind = REG_STAT;
      else if (lo_i == OFS_IE)   sel.kind = REG_IE;
      else if (lo_i == OFS_CAP)  sel.kind = REG_CAP;
      else if (lo_i >= OFS_MATCH && lo_i < OFS_MATCH + NCMP) begin
        sel.kind = REG_MATCH;
        sel.idx  = 8'(lo_i - OFS_MATCH);
      end
    end
  end

  // Read response
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= acc && !bus_write;
      if (acc && !bus_write) rd_data <= rd_word;
    end
  end

  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_ready && !bus_write) |=> rd_valid); // R10
  AST_NO_SPURIOUS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(bus_valid && bus_ready && !bus_write)); // R10
endmodule

// File: rtl/mtmr_cmp.sv
module mtmr_cmp #(
  parameter int unsigned CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [CW-1:0] wdata,
  input  logic [CW-1:0] count,
  output logic [CW-1:0] value,
  output logic          eq
);
  always_ff @(posedge clk) begin
    if (!rst_n)  value <= '1;
    else if (we) value <= wdata;
  end

  assign eq = (count == value);
endmodule

// File: rtl/mtmr_capture.sv
module mtmr_capture #(
  parameter int unsigned CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [CW-1:0] count,
  output logic [CW-1:0] value,
  output logic          busy
);
  logic [CW-1:0] snap_q;
  logic          p0_q, p1_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      snap_q <= '0;
      value  <= '0;
      p0_q   <= 1'b0;
      p1_q   <= 1'b0;
    end else begin
      if (we) snap_q <= count;
      p0_q <= we;
      p1_q <= p0_q;
      if (p1_q) value <= snap_q;
    end
  end

  assign busy = p0_q || p1_q;

  AST_BUSY_TWO_CYCLES: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |=> busy); // R9
  AST_CAPTURE_STABLE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !we) |=> $stable(value)); // R9
endmodule

// File: rtl/mtmr_channel.sv
module mtmr_channel #(
  parameter int unsigned CW   = 32,
  parameter int unsigned NCMP = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               run,
  input  logic               start,
  input  logic               periodic,
  input  logic               stat_we,
  input  logic               ie_we,
  input  logic               cap_we,
  input  logic [NCMP-1:0]    match_we,
  input  logic [CW-1:0]      wdata,
  output logic [NCMP-1:0]    status,
  output logic [NCMP-1:0]    ie,
  output logic [CW-1:0]      cap_val,
  output logic               busy,
  output logic [NCMP*CW-1:0] match_flat,
  output logic               irq_req
);
  logic [CW-1:0]   count_q, count_d;
  logic [NCMP-1:0] eq, hit, clr;
  logic            adv, reload;

  for (genvar k = 0; k < NCMP; k++) begin : g_cmp
    mtmr_cmp #(.CW(CW)) u_cmp (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (match_we[k]),
      .wdata (wdata),
      .count (count_q),
      .value (match_flat[k*CW +: CW]),
      .eq    (eq[k])
    );
  end

  mtmr_capture #(.CW(CW)) u_cap (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cap_we),
    .count (count_q),
    .value (cap_val),
    .busy  (busy)
  );

  assign adv    = run && tick && !start;
  assign hit    = adv ? eq : '0;
  assign reload = periodic && hit[0];
  assign clr    = stat_we ? wdata[NCMP-1:0] : '0;

  always_comb begin
    count_d = count_q;
    if (start)    count_d = '0;
    else if (adv) count_d = reload ? '0 : count_q + CW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q <= '0;
      status  <= '0;
      ie      <= '0;
    end else begin
      count_q <= count_d;
      status  <= (status & ~clr) | hit;   // a match beats a same-cycle clear
      if (ie_we) ie <= wdata[NCMP-1:0];
    end
  end

  assign irq_req = |(status & ie);

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (count_q == '0)); // R1
  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !start) |=> $stable(count_q)); // R2
  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !start) |=> $stable(count_q)); // R3
  AST_MATCH_SETS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && eq[0]) |=> status[0]); // R4
  AST_PERIODIC_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && periodic && eq[0]) |=> (count_q == '0)); // R5
  AST_FREE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !periodic && (&count_q)) |=> (count_q == '0)); // R6
  AST_FREE_NO_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !periodic && !(&count_q)) |=> (count_q == $past(count_q) + CW'(1))); // R6
  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status & $past(status & ~clr)) == $past(status & ~clr))); // R7
endmodule

// File: rtl/match_timer.sv
module match_timer
  import mtmr_pkg::*;
#(
  parameter int unsigned NCNT = 3,
  parameter int unsigned NCMP = 3,
  parameter int unsigned CW   = 32,
  parameter int unsigned AW   = 8,
  parameter int unsigned DW   = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          bus_valid,
  output logic          bus_ready,
  input  logic          bus_write,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic          irq
);
  localparam int unsigned CHW = (NCNT > 1) ? $clog2(NCNT) : 1;
  localparam int unsigned CMW = (NCMP > 1) ? $clog2(NCMP) : 1;

  reg_sel_t        sel;
  logic            wr_acc;
  logic [DW-1:0]   rd_word;
  logic [NCNT-1:0] run_q, mode_q, start, busy_v, irq_v, ie_nz, st_nz;
  logic            run_we, mode_we;
  logic [CW-1:0]   wdata_c;

  logic [NCMP-1:0]    stat_a [NCNT];
  logic [NCMP-1:0]    ie_a   [NCNT];
  logic [CW-1:0]      cap_a  [NCNT];
  logic [NCMP*CW-1:0] mflat  [NCNT];
  logic [CW-1:0]      mval   [NCNT][NCMP];

  mtmr_bus #(.AW(AW), .DW(DW), .NCNT(NCNT), .NCMP(NCMP)) u_bus (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_ready (bus_ready),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data),
    .rd_word   (rd_word),
    .sel       (sel),
    .wr_acc    (wr_acc)
  );

  assign wdata_c = CW'(bus_wdata);
  assign run_we  = wr_acc && (sel.kind == REG_RUN);
  assign mode_we = wr_acc && (sel.kind == REG_MODE);
  assign start   = run_we ? (bus_wdata[NCNT-1:0] & ~run_q) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q  <= '0;
      mode_q <= '0;
    end else begin
      if (run_we)  run_q  <= bus_wdata[NCNT-1:0];
      if (mode_we) mode_q <= bus_wdata[NCNT-1:0];
    end
  end

  for (genvar c = 0; c < NCNT; c++) begin : g_ch
    logic            ch_hit;
    logic [NCMP-1:0] mwe;

    assign ch_hit = wr_acc && (sel.ch == 8'(c));
    for (genvar k = 0; k < NCMP; k++) begin : g_mwe
      assign mwe[k]     = ch_hit && (sel.kind == REG_MATCH) && (sel.idx == 8'(k));
      assign mval[c][k] = mflat[c][k*CW +: CW];
    end

    mtmr_channel #(.CW(CW), .NCMP(NCMP)) u_chan (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (tick),
      .run        (run_q[c]),
      .start      (start[c]),
      .periodic   (mode_q[c]),
      .stat_we    (ch_hit && (sel.kind == REG_STAT)),
      .ie_we      (ch_hit && (sel.kind == REG_IE)),
      .cap_we     (ch_hit && (sel.kind == REG_CAP)),
      .match_we   (mwe),
      .wdata      (wdata_c),
      .status     (stat_a[c]),
      .ie         (ie_a[c]),
      .cap_val    (cap_a[c]),
      .busy       (busy_v[c]),
      .match_flat (mflat[c]),
      .irq_req    (irq_v[c])
    );

    assign ie_nz[c] = |ie_a[c];
    assign st_nz[c] = |stat_a[c];
  end

  // Read mux
  always_comb begin
    rd_word = '0;
    unique case (sel.kind)
      REG_RUN:   rd_word[NCNT-1:0] = run_q;
      REG_MODE:  rd_word[NCNT-1:0] = mode_q;
      REG_BUSY:  rd_word[NCNT-1:0] = busy_v;
      REG_STAT:  rd_word[NCMP-1:0] = stat_a[sel.ch[CHW-1:0]];
      REG_IE:    rd_word[NCMP-1:0] = ie_a[sel.ch[CHW-1:0]];
      REG_CAP:   rd_word = DW'(cap_a[sel.ch[CHW-1:0]]);
      REG_MATCH: rd_word = DW'(mval[sel.ch[CHW-1:0]][sel.idx[CMW-1:0]]);
      default:   rd_word = '0;
    endcase
  end

  assign irq = |irq_v;

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (ie_nz == '0) |-> !irq); // R8
  AST_IRQ_NEEDS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (st_nz != '0)); // R8
endmodule

// File: tb/match_timer_bench.sv
module match_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n, tick, bus_valid, bus_write;
  logic        bus_ready, rd_valid, irq;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, rd_data;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  match_timer u_match_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .bus_valid (bus_valid),
    .bus_ready (bus_ready),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data),
    .irq       (irq)
  );

  localparam logic [7:0] A_RUN = 8'h00, A_MODE = 8'h01, A_BUSY = 8'h02;

  function automatic logic [7:0] a_ch(input int c, input int o);
    return 8'(16 + 8 * c + o);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_valid = 1'b0;
    d = rd_data;
  endtask

  task automatic ticks(input int n);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic grab(input int c, output logic [31:0] v);
    wr(a_ch(c, 2), 32'h0);
    repeat (2) @(negedge clk);
    rd(a_ch(c, 2), v);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    check("R10 ready after reset", 32'(bus_ready), 32'h1);
    check("R11 irq low", 32'(irq), 32'h0);
    rd(A_RUN, v);          check("R11 run reg", v, 32'h0);
    rd(A_MODE, v);         check("R11 mode reg", v, 32'h0);
    rd(A_BUSY, v);         check("R11 busy reg", v, 32'h0);
    rd(a_ch(0, 3), v);     check("R11 match value", v, 32'hFFFF_FFFF);
    rd(a_ch(2, 5), v);     check("R11 match value ch2 k2", v, 32'hFFFF_FFFF);
    rd(a_ch(1, 0), v);     check("R11 status", v, 32'h0);
  endtask

  task automatic t_count;
    logic [31:0] v;
    wr(A_RUN, 32'h1);
    ticks(10);
    grab(0, v);            check("R2 count after 10 ticks", v, 32'd10);
    repeat (5) @(negedge clk);
    grab(0, v);            check("R2 no change without tick", v, 32'd10);
  endtask

  task automatic t_freeze_capture;
    logic [31:0] v;
    wr(A_RUN, 32'h0);
    ticks(5);
    grab(0, v);            check("R3 frozen while off", v, 32'd10);
    wr(A_RUN, 32'h1);
    grab(0, v);            check("R1 restart clears count", v, 32'd0);
    wr(a_ch(0, 2), 32'h0);                 // latch at count 0
    rd(A_BUSY, v);         check("R9 busy after capture write", v & 32'h1, 32'h1);
    ticks(3);
    rd(A_BUSY, v);         check("R9 busy cleared", v & 32'h1, 32'h0);
    rd(a_ch(0, 2), v);     check("R9 latched value unaffected by later ticks", v, 32'd0);
    grab(0, v);            check("R9 fresh capture", v, 32'd3);
  endtask

  task automatic t_match_irq;
    logic [31:0] v;
    wr(a_ch(1, 3), 32'd4);
    wr(a_ch(1, 1), 32'h1);
    wr(A_RUN, 32'h2);
    ticks(4);
    rd(a_ch(1, 0), v);     check("R4 no match before Nth tick", v, 32'h0);
    check("R8 irq low before match", 32'(irq), 32'h0);
    ticks(1);
    rd(a_ch(1, 0), v);     check("R4 match on 5th tick", v, 32'h1);
    check("R8 irq high", 32'(irq), 32'h1);
    ticks(1);
    grab(1, v);            check("R6 free-running passes match", v, 32'd6);
    wr(a_ch(1, 1), 32'h0); check("R8 irq masked", 32'(irq), 32'h0);
    wr(a_ch(1, 1), 32'h1); check("R8 irq unmasked", 32'(irq), 32'h1);
    wr(a_ch(1, 0), 32'h6);
    rd(a_ch(1, 0), v);     check("R7 write 0 keeps bit", v, 32'h1);
    wr(a_ch(1, 0), 32'h1);
    rd(a_ch(1, 0), v);     check("R7 write 1 clears bit", v, 32'h0);
    check("R8 irq low after clear", 32'(irq), 32'h0);
  endtask

  task automatic t_periodic;
    logic [31:0] v;
    wr(A_MODE, 32'h4);
    wr(a_ch(2, 3), 32'd3);
    wr(a_ch(2, 4), 32'd1);
    wr(A_RUN, 32'h4);
    ticks(4);
    rd(a_ch(2, 0), v);     check("R5 both comparators fired", v, 32'h3);
    grab(2, v);            check("R5 reload after match0", v, 32'd0);
    wr(a_ch(2, 0), 32'h7);
    ticks(2);
    rd(a_ch(2, 0), v);     check("R5 only comparator 1", v, 32'h2);
    grab(2, v);            check("R5 comparator 1 no reload", v, 32'd2);
    ticks(2);
    grab(2, v);            check("R5 period of 4 ticks", v, 32'd0);
    wr(A_RUN, 32'h0);
    ticks(3);
    rd(a_ch(2, 0), v);     check("R3 status kept while off", v, 32'h3);
  endtask

  task automatic t_collision;
    logic [31:0] v;
    wr(A_MODE, 32'h0);
    wr(a_ch(0, 3), 32'd2);
    wr(A_RUN, 32'h1);
    ticks(2);
    tick = 1'b1;
    wr(a_ch(0, 0), 32'h1);                 // clear and match in the same cycle
    tick = 1'b0;
    rd(a_ch(0, 0), v);     check("R7 set beats clear", v, 32'h1);
    wr(a_ch(0, 0), 32'h1);
    rd(a_ch(0, 0), v);     check("R7 later clear", v, 32'h0);
  endtask

  task automatic t_bus;
    logic [31:0] v;
    wr(8'h7F, 32'hFFFF_FFFF);
    wr(8'h09, 32'hFFFF_FFFF);
    rd(A_RUN, v);          check("R10 unmapped write ignored (run)", v, 32'h1);
    check("R10 rd_valid with data", 32'(rd_valid), 32'h1);
    @(negedge clk);
    check("R10 rd_valid single pulse", 32'(rd_valid), 32'h0);
    rd(A_MODE, v);         check("R10 unmapped write ignored (mode)", v, 32'h0);
    rd(8'h7F, v);          check("R10 unmapped read zero", v, 32'h0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; tick = 1'b0; bus_valid = 1'b0; bus_write = 1'b0;
    bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_count();
    t_freeze_capture();
    t_match_irq();
    t_periodic();
    t_collision();
    t_bus();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule